// File: doc/BRIEF.md
# Stack Pointer and Call/Return Unit

This block keeps the stack pointer of a processor whose stack holds 32-bit words in byte-addressed memory. The stack grows toward address zero. The block carries out four stack operations: push a register, pop into a register, call a subroutine and return from it. For each operation it forms the memory address and the new stack pointer. It picks the word to store, or routes the loaded word to the register file or to the program counter.

An operation is accepted in a cycle where `ready_o` and `op_valid_i` are both high. The block then holds one memory request until the memory acknowledges it. In the cycle after the acknowledge, the block presents the result for one cycle with `done_o`. A push or call that would form an address below zero is refused: the block raises `fault_o` with `done_o`, makes no memory access and leaves the stack pointer where it was.

Top module: `stack_unit`

## Requirements
- R1: After reset, `sp_o` equals the word-aligned parameter `SP_RESET`, `ready_o` is 1, and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: A push (op code 0) writes `reg_data_i` to address SP-4. At completion SP becomes SP-4. Neither `rf_we_o` nor `pc_we_o` is raised.
- R3: A pop (op code 1) reads the word at SP. At completion it raises `rf_we_o` with that word on `rf_wdata_o` and the latched `dst_idx_i` on `rf_waddr_o`, and SP becomes SP+4.
- R4: A call (op code 2) writes `pc_i`+4 to address SP-4. At completion it raises `pc_we_o` with `target_i` on `pc_next_o`, and SP becomes SP-4.
- R5: A return (op code 3) reads the word at SP. At completion it raises `pc_we_o` with that word on `pc_next_o`, and SP becomes SP+4.
- R6: A push or call with SP below 4 makes no memory request. One cycle after acceptance it gives `done_o`=1 and `fault_o`=1, SP is unchanged, and neither `rf_we_o` nor `pc_we_o` is raised.
- R7: While a request waits for `mem_ack_i`, the request, address, write enable and write data stay constant, and SP does not change.
- R8: `op_valid_i` is ignored while `ready_o` is 0. An operation offered during a pending request has no effect on the request or on the result.
- R9: `done_o` rises in the cycle after the acknowledge. Every memory address has its two low bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_i | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| reg_data_i | input | DATA_W | Register value to push |
| dst_idx_i | input | REG_IDX_W | Destination register for pop |
| pc_i | input | ADDR_W | Address of the call instruction |
| target_i | input | ADDR_W | Call target |
| ready_o | output | 1 | Idle, can accept an operation |
| sp_o | output | ADDR_W | Current stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory completes the request |
| mem_rdata_i | input | DATA_W | Read data, valid with ack |
| done_o | output | 1 | Result cycle |
| fault_o | output | 1 | Stack fault, with done |
| rf_we_o | output | 1 | Register write for pop |
| rf_waddr_o | output | REG_IDX_W | Register index |
| rf_wdata_o | output | DATA_W | Register value |
| pc_we_o | output | 1 | Program counter load |
| pc_next_o | output | ADDR_W | New program counter |

## Verification
The bench drives SP down to exactly 4 and pushes once more, to 0. A comparison that is off by one would fault too early here, or would let the address wrap to the top of memory. It then tries a push and a call at SP 0 and expects faults with no memory access; a design that committed SP on a fault would drift. Returns are checked after calls, so a design that pushed `pc_i` instead of `pc_i`+4 would resume at the call itself. Acknowledges are delayed at random and new operations are offered during the wait, which exposes a request that changes before its acknowledge or a busy block that accepts a second operation.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_DONE = 2'd2
  } stk_state_e;

  function automatic logic op_is_write(stk_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic op_to_pc(stk_op_e op);
    return (op == OP_CALL) || (op == OP_RET);
  endfunction
endpackage

// File: rtl/stack_addr_gen.sv
module stack_addr_gen
  import stack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] sp_i,
  input  stk_op_e           op_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] sp_next_o,
  output logic              fault_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] dec_w, inc_w;
  assign dec_w = sp_i - STEP_V;
  assign inc_w = sp_i + STEP_V;

  always_comb begin
    if (op_is_write(op_i)) begin
      // pre-decrement: slot below the current top
      addr_o    = dec_w;
      sp_next_o = dec_w;
      fault_o   = (sp_i < STEP_V);
    end else begin
      addr_o    = sp_i;
      sp_next_o = inc_w;
      fault_o   = 1'b0;
    end
  end
endmodule

// File: rtl/stack_fsm.sv
module stack_fsm
  import stack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fault_i,
  input  logic       mem_ack_i,
  output logic       ready_o,
  output logic       mem_req_o,
  output logic       done_o,
  output logic       accept_o,
  output logic       commit_o
);
  stk_state_e state_q, state_d;

  assign ready_o   = (state_q == ST_IDLE);
  assign mem_req_o = (state_q == ST_MEM);
  assign done_o    = (state_q == ST_DONE);
  assign accept_o  = ready_o && start_i;
  assign commit_o  = mem_req_o && mem_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = fault_i ? ST_DONE : ST_MEM;
      ST_MEM:  if (mem_ack_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/stack_unit.sv
module stack_unit
  import stack_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 32,
  parameter int          REG_IDX_W   = 5,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] SP_RESET    = 32'h0000_0400
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [1:0]           op_i,
  input  logic [DATA_W-1:0]    reg_data_i,
  input  logic [REG_IDX_W-1:0] dst_idx_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [ADDR_W-1:0]    target_i,
  output logic                 ready_o,
  output logic [ADDR_W-1:0]    sp_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [DATA_W-1:0]    rf_wdata_o,
  output logic                 pc_we_o,
  output logic [ADDR_W-1:0]    pc_next_o
);
  localparam int STEP = DATA_W / 8;
  localparam logic [ADDR_W-1:0] RET_OFS = ADDR_W'(INSTR_BYTES);

  stk_op_e             op_w, op_q;
  logic [ADDR_W-1:0]   sp_q, addr_w, sp_next_w, addr_q, sp_next_q, tgt_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic [REG_IDX_W-1:0] dst_q;
  logic                fault_w, fault_q, accept_w, commit_w;

  assign op_w = stk_op_e'(op_i);

  stack_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .sp_i      (sp_q),
    .op_i      (op_w),
    .addr_o    (addr_w),
    .sp_next_o (sp_next_w),
    .fault_o   (fault_w)
  );

  stack_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (op_valid_i),
    .fault_i   (fault_w),
    .mem_ack_i (mem_ack_i),
    .ready_o   (ready_o),
    .mem_req_o (mem_req_o),
    .done_o    (done_o),
    .accept_o  (accept_w),
    .commit_o  (commit_w)
  );

  // operation latch, taken only when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_PUSH;
      addr_q    <= '0;
      sp_next_q <= '0;
      tgt_q     <= '0;
      wdata_q   <= '0;
      dst_q     <= '0;
      fault_q   <= 1'b0;
    end else if (accept_w) begin
      op_q      <= op_w;
      addr_q    <= addr_w;
      sp_next_q <= sp_next_w;
      tgt_q     <= target_i;
      dst_q     <= dst_idx_i;
      fault_q   <= fault_w;
      wdata_q   <= (op_w == OP_CALL) ? DATA_W'(pc_i + RET_OFS) : reg_data_i;
    end
  end

  // sp and read data commit on the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= ADDR_W'(SP_RESET);
      rdata_q <= '0;
    end else if (commit_w) begin
      sp_q    <= sp_next_q;
      rdata_q <= mem_rdata_i;
    end
  end

  assign sp_o        = sp_q;
  assign mem_we_o    = mem_req_o && op_is_write(op_q);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  logic ok_w;
  assign ok_w       = done_o && !fault_q;
  assign fault_o    = done_o && fault_q;
  assign rf_we_o    = ok_w && (op_q == OP_POP);
  assign rf_waddr_o = dst_q;
  assign rf_wdata_o = rdata_q;
  assign pc_we_o    = ok_w && op_to_pc(op_q);
  assign pc_next_o  = (op_q == OP_CALL) ? tgt_q : ADDR_W'(rdata_q);
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] SP_RESET = 32'h0000_0400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic              fault_o,
  input logic              rf_we_o,
  input logic              pc_we_o
);
  initial begin
    a_reset_align_r1: assert (SP_RESET[1:0] == 2'b00);
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_sp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(sp_o));

  p_fault_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && !mem_req_o && !rf_we_o && !pc_we_o);

  p_fault_sp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> $stable(sp_o));

  p_sp_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |->
      (sp_o == $past(sp_o) + ADDR_W'(4)) || (sp_o == $past(sp_o) - ADDR_W'(4)));

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> done_o);

  p_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> !ready_o);

  p_one_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, pc_we_o}));
endmodule

bind stack_unit stack_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_RESET(SP_RESET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .sp_o(sp_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .done_o(done_o),
  .fault_o(fault_o), .rf_we_o(rf_we_o), .pc_we_o(pc_we_o)
);

// File: tb/stack_unit_tb.sv
`timescale 1ns/1ps
module stack_unit_tb;
  localparam logic [31:0] SPR = 32'd64;

  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0;
  logic [1:0]  op = 0;
  logic [31:0] reg_data = 0, pc = 0, target = 0, mem_rdata = 0;
  logic [4:0]  dst = 0;
  logic        mem_ack = 0;
  logic        ready, mem_req, mem_we, done, fault, rf_we, pc_we;
  logic [31:0] sp, mem_addr, mem_wdata, rf_wdata, pc_next;
  logic [4:0]  rf_waddr;

  int checks = 0, fails = 0;
  logic [31:0] sp_m;
  logic [31:0] mem_m [64];
  bit finished = 0;

  always #2 clk = ~clk;

  stack_unit #(.SP_RESET(SPR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .reg_data_i(reg_data), .dst_idx_i(dst), .pc_i(pc), .target_i(target),
    .ready_o(ready), .sp_o(sp), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .pc_we_o(pc_we), .pc_next_o(pc_next)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_wr(logic [1:0] o);
    return (o == 2'd0) || (o == 2'd2);
  endfunction

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(logic [1:0] o, logic [31:0] d, logic [4:0] di,
                        logic [31:0] p, logic [31:0] t, int stall, bit poke);
    bit          ef;
    logic [31:0] ea, ew, er, esp;
    string       rq;
    rq  = req_of(o);
    ef  = is_wr(o) && (sp_m < 32'd4);
    ea  = is_wr(o) ? sp_m - 32'd4 : sp_m;
    esp = is_wr(o) ? sp_m - 32'd4 : sp_m + 32'd4;
    ew  = (o == 2'd2) ? p + 32'd4 : d;
    @(negedge clk);
    chk(ready == 1'b1, "R8", "ready before op", {31'b0, ready}, 32'd1);
    op_valid = 1; op = o; reg_data = d; dst = di; pc = p; target = t;
    @(negedge clk);
    op_valid = 0;
    reg_data = ~d; pc = ~p; target = ~t; dst = ~di;
    if (ef) begin
      chk(done && fault, "R6", "done/fault", {30'b0, done, fault}, 32'd3);
      chk(!mem_req && !rf_we && !pc_we, "R6", "no side effect",
          {29'b0, mem_req, rf_we, pc_we}, 32'd0);
      chk(sp == sp_m, "R6", "sp kept", sp, sp_m);
      return;
    end
    for (int s = 0; s < stall; s++) begin
      chk(mem_req && sp == sp_m, "R7", "waiting req/sp", sp, sp_m);
      if (poke && s == 0) begin
        op_valid = 1; op = ~o; reg_data = 32'hDEAD_BEEF;
      end
      @(negedge clk);
      op_valid = 0;
    end
    chk(mem_req == 1'b1, "R7", "req", {31'b0, mem_req}, 32'd1);
    chk(mem_addr == ea, rq, "addr", mem_addr, ea);
    chk(mem_addr[1:0] == 2'b00, "R9", "align", mem_addr, ea);
    chk(mem_we == is_wr(o), rq, "we", {31'b0, mem_we}, {31'b0, is_wr(o)});
    if (is_wr(o)) chk(mem_wdata == ew, rq, "wdata", mem_wdata, ew);
    er = mem_m[ea[7:2]];
    mem_ack = 1; mem_rdata = er;
    if (is_wr(o)) mem_m[ea[7:2]] = ew;
    @(negedge clk);
    mem_ack = 0; mem_rdata = $urandom;
    chk(done && !fault, "R9", "done after ack", {30'b0, done, fault}, 32'd2);
    chk(sp == esp, rq, "sp", sp, esp);
    case (o)
      2'd0: chk(!rf_we && !pc_we, "R2", "no writeback", {30'b0, rf_we, pc_we}, 0);
      2'd1: begin
        chk(rf_we && !pc_we, "R3", "rf_we", {30'b0, rf_we, pc_we}, 32'd2);
        chk(rf_wdata == er, "R3", "rf data", rf_wdata, er);
        chk(rf_waddr == di, "R3", "rf idx", {27'b0, rf_waddr}, {27'b0, di});
      end
      2'd2: begin
        chk(pc_we && !rf_we, "R4", "pc_we", {30'b0, rf_we, pc_we}, 32'd1);
        chk(pc_next == t, "R4", "target", pc_next, t);
      end
      default: begin
        chk(pc_we && !rf_we, "R5", "pc_we", {30'b0, rf_we, pc_we}, 32'd1);
        chk(pc_next == er, "R5", "return pc", pc_next, er);
      end
    endcase
    sp_m = esp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem_m[i] = $urandom;
    sp_m = SPR;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp == SPR, "R1", "reset sp", sp, SPR);
    chk(ready && !mem_req && !done && !fault, "R1", "reset flags",
        {28'b0, ready, mem_req, done, fault}, 32'd8);
    rst_n = 1;
    // R2 / R3 basic
    run_op(2'd0, 32'h1234_5678, 5'd1, 0, 0, 0, 0);
    run_op(2'd1, 0, 5'd7, 0, 0, 0, 0);
    // R4 / R5 call then return lands after the call
    run_op(2'd2, 0, 0, 32'h0000_1000, 32'h0000_2000, 1, 0);
    run_op(2'd3, 0, 0, 0, 0, 2, 0);
    // R8 busy pokes
    run_op(2'd0, 32'hCAFE_0001, 0, 0, 0, 2, 1);
    run_op(2'd1, 0, 5'd3, 0, 0, 1, 1);
    // R6 drive to bottom, then fault
    while (sp_m > 32'd4) run_op(2'd0, $urandom, 0, 0, 0, $urandom_range(0, 2), 0);
    run_op(2'd2, 0, 0, 32'h40, 32'h80, 0, 0);
    run_op(2'd0, 32'h5555_AAAA, 0, 0, 0, 0, 0);
    run_op(2'd2, 0, 0, 32'h44, 32'h88, 0, 0);
    run_op(2'd1, 0, 5'd9, 0, 0, 1, 0);
    run_op(2'd0, 32'h0BAD_F00D, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ro;
      ro = 2'($urandom_range(0, 3));
      if (sp_m >= 32'd240) ro = 2'd0;
      run_op(ro, $urandom, 5'($urandom), $urandom & 32'hFFFF_FFFC,
             $urandom, $urandom_range(0, 3), $urandom_range(0, 3) == 0);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule